// File: doc/BRIEF.md
# Fixed-OR Sum-of-Products Logic Cell Array

This block is a soft model of a small programmable sum-of-products device. Ten dedicated input pins and six fed-back output pins form a 16-signal array. Every product term may connect the true form, the complemented form, both, or neither of each array signal. Each of the eight outputs has its own fixed group of seven product terms. The OR of that group is inverted to give the output value. An eighth term for each output drives its three-state enable. The fuse map is held in registers and loaded one product term at a time through a configuration port. The logic path from the pins to the outputs is combinational.

Outputs 1 to 6 feed back into the array. While such an output is enabled, the array sees the value the block drives. While it is disabled, the array sees the external pin value on `io_in`, so that output pin becomes an extra input. A function that needs more than seven terms can place some of them on a helper output and read that output back on a second pass. Feedback is resolved by a fixed number of unrolled passes. Configurations that contain a combinational loop are not supported.

Top module: `pal_cell_array`

## Requirements
- R1: After reset every fuse is intact, so every term is 0. All `out_en` bits are then 0 and all `out_val` bits are 1 until the first configuration write.
- R2: Array signal s is `ded_in[s]` for s = 0..9 and is the feedback of output s-9 for s = 10..15. Fuse bit 2s of a term connects the true form of signal s, and bit 2s+1 connects the complemented form. A term is the AND of its connected literals, so a term with no fuses connected is 1.
- R3: `out_val[o]` is the inverse of the OR of terms 0..6 of output o.
- R4: Term 7 of output o drives `out_en[o]` directly. An empty enable term keeps the output enabled at all times.
- R5: Programming the terms of one output has no effect on the value or enable of any other output, except through feedback.
- R6: An enabled output among 1..6 feeds its own value into the array. Helper chains up to two levels deep settle to the correct values.
- R7: When output o (1..6) is disabled, its feedback signal takes `io_in[o]`. When it is enabled, `io_in[o]` has no effect.
- R8: A cycle with `cfg_we` high replaces all 32 fuses of term `cfg_term` (7 selects the enable term) of output `cfg_out` with `cfg_fuses`. The change is visible after that clock edge.
- R9: `io_in[0]` and `io_in[7]` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fuse registers |
| rst_n | input | 1 | Active-low reset; sets every fuse to intact |
| cfg_we | input | 1 | Write strobe for one product term |
| cfg_out | input | 3 | Output whose term is written |
| cfg_term | input | 3 | Term index; 0..6 are sum terms, 7 is the enable term |
| cfg_fuses | input | 32 | New fuse pattern, two bits per array signal |
| ded_in | input | 10 | Dedicated input pins |
| io_in | input | 8 | External level at each output pin |
| out_val | output | 8 | Inverted sum-of-products value of each output |
| out_en | output | 8 | Three-state enable of each output |

## Verification
The assertions assume that the inputs are settled at each clock edge. They also assume that every loaded fuse map is free of combinational loops and has helper chains no deeper than the number of unrolled passes minus one. Only under those conditions do the final-pass terms and outputs match a fully settled array. The stimulus changes inputs one time unit after a rising edge and checks at the falling edge. It programs only acyclic feedback, and its deepest chain runs through two outputs.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int N_DED    = 10;
  localparam int N_OUT    = 8;
  localparam int N_SUM    = 7;
  localparam int N_FB     = 6;
  localparam int FB_FIRST = 1;
  localparam int N_SIG    = N_DED + N_FB;
  localparam int LIT_W    = 2 * N_SIG;
  localparam int TPO      = N_SUM + 1;
  localparam int EN_TERM  = N_SUM;
  localparam int OIDX_W   = $clog2(N_OUT);
  localparam int TIDX_W   = $clog2(TPO);

  typedef logic [LIT_W-1:0]          term_fuse_t;
  typedef term_fuse_t [TPO-1:0]      cell_fuse_t;
  typedef cell_fuse_t [N_OUT-1:0]    fuse_map_t;
  typedef logic [TPO-1:0]            cell_terms_t;
  typedef cell_terms_t [N_OUT-1:0]   array_terms_t;

  // AND of every connected literal; bit 2s = true form, bit 2s+1 = complement.
  function automatic logic eval_term(input term_fuse_t fuses,
                                     input logic [N_SIG-1:0] sig);
    logic r;
    r = 1'b1;
    for (int s = 0; s < N_SIG; s++) begin
      if (fuses[2*s] && !sig[s])     r = 1'b0;
      if (fuses[2*s+1] && sig[s])    r = 1'b0;
    end
    return r;
  endfunction

  // Inverted OR of the fixed sum-term group of one output.
  function automatic logic or_invert(input cell_terms_t t);
    logic any;
    any = 1'b0;
    for (int k = 0; k < N_SUM; k++) any = any | t[k];
    return ~any;
  endfunction

  // Feedback source per fed-back output: own value when enabled, pin otherwise.
  function automatic logic [N_FB-1:0] fb_select(input logic [N_OUT-1:0] v,
                                                input logic [N_OUT-1:0] e,
                                                input logic [N_OUT-1:0] io);
    logic [N_FB-1:0] r;
    for (int j = 0; j < N_FB; j++)
      r[j] = e[FB_FIRST+j] ? v[FB_FIRST+j] : io[FB_FIRST+j];
    return r;
  endfunction
endpackage

// File: rtl/pal_fuse_store.sv
module pal_fuse_store
  import pal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [OIDX_W-1:0] cfg_out,
  input  logic [TIDX_W-1:0] cfg_term,
  input  logic [LIT_W-1:0]  cfg_fuses,
  output fuse_map_t         fuse_map
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    for (genvar t = 0; t < TPO; t++) begin : g_term
      logic             hit;
      logic [LIT_W-1:0] q;
      assign hit = cfg_we && (cfg_out == OIDX_W'(o)) && (cfg_term == TIDX_W'(t));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '1;
        else if (hit) q <= cfg_fuses;
      end
      assign fuse_map[o][t] = q;
    end
  end
endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane
  import pal_pkg::*;
(
  input  logic [N_SIG-1:0] sig,
  input  fuse_map_t        fuse_map,
  output array_terms_t     terms
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    for (genvar t = 0; t < TPO; t++) begin : g_term
      assign terms[o][t] = eval_term(fuse_map[o][t], sig);
    end
  end
endmodule

// File: rtl/pal_or_stage.sv
module pal_or_stage
  import pal_pkg::*;
(
  input  array_terms_t     terms,
  output logic [N_OUT-1:0] out_v,
  output logic [N_OUT-1:0] out_e
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign out_v[o] = or_invert(terms[o]);
    assign out_e[o] = terms[o][EN_TERM];
  end
endmodule

// File: rtl/pal_cell_array.sv
module pal_cell_array
  import pal_pkg::*;
#(
  parameter int PASSES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [OIDX_W-1:0] cfg_out,
  input  logic [TIDX_W-1:0] cfg_term,
  input  logic [LIT_W-1:0]  cfg_fuses,
  input  logic [N_DED-1:0]  ded_in,
  input  logic [N_OUT-1:0]  io_in,
  output logic [N_OUT-1:0]  out_val,
  output logic [N_OUT-1:0]  out_en
);
  fuse_map_t    fuse_map;
  array_terms_t final_terms;

  pal_fuse_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_out   (cfg_out),
    .cfg_term  (cfg_term),
    .cfg_fuses (cfg_fuses),
    .fuse_map  (fuse_map)
  );

  // Feedback is unrolled: pass 0 sees every feedback pin as disabled,
  // each later pass sees the outputs of the pass before it.
  for (genvar p = 0; p < PASSES; p++) begin : g_pass
    logic [N_FB-1:0]  fb;
    logic [N_SIG-1:0] sig;
    array_terms_t     t;
    logic [N_OUT-1:0] v;
    logic [N_OUT-1:0] e;

    if (p == 0) begin : g_first
      assign fb = fb_select('0, '0, io_in);
    end else begin : g_next
      assign fb = fb_select(g_pass[p-1].v, g_pass[p-1].e, io_in);
    end

    assign sig = {fb, ded_in};

    pal_and_plane u_and (
      .sig      (sig),
      .fuse_map (fuse_map),
      .terms    (t)
    );

    pal_or_stage u_or (
      .terms (t),
      .out_v (v),
      .out_e (e)
    );
  end

  assign final_terms = g_pass[PASSES-1].t;
  assign out_val     = g_pass[PASSES-1].v;
  assign out_en      = g_pass[PASSES-1].e;
endmodule

// File: rtl/pal_cell_array_chk.sv
module pal_cell_array_chk
  import pal_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [OIDX_W-1:0] cfg_out,
  input logic [TIDX_W-1:0] cfg_term,
  input logic [LIT_W-1:0]  cfg_fuses,
  input logic [N_OUT-1:0]  out_val,
  input logic [N_OUT-1:0]  out_en,
  input fuse_map_t         fuse_map,
  input array_terms_t      final_terms
);
  logic              wr_seen;
  logic              last_we;
  logic [OIDX_W-1:0] last_o;
  logic [TIDX_W-1:0] last_t;
  logic [LIT_W-1:0]  last_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_seen <= 1'b0;
      last_we <= 1'b0;
      last_o  <= '0;
      last_t  <= '0;
      last_f  <= '0;
    end else begin
      if (cfg_we) wr_seen <= 1'b1;
      last_we <= cfg_we;
      last_o  <= cfg_out;
      last_t  <= cfg_term;
      last_f  <= cfg_fuses;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_seen |-> (out_en == '0 && out_val == '1));

  assert_cfg_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_we |-> fuse_map[last_o][last_t] == last_f);

  for (genvar o = 0; o < N_OUT; o++) begin : g_o
    assert_sum_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|final_terms[o][N_SUM-1:0]) |-> !out_val[o]);
    assert_sum_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(|final_terms[o][N_SUM-1:0]) |-> out_val[o]);
    assert_empty_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fuse_map[o][EN_TERM] == '0) |-> out_en[o]);
    for (genvar t = 0; t < TPO; t++) begin : g_t
      assert_intact_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_map[o][t] == '1) |-> !final_terms[o][t]);
    end
  end
endmodule

bind pal_cell_array pal_cell_array_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_out     (cfg_out),
  .cfg_term    (cfg_term),
  .cfg_fuses   (cfg_fuses),
  .out_val     (out_val),
  .out_en      (out_en),
  .fuse_map    (fuse_map),
  .final_terms (final_terms)
);

// File: tb/tb_pal_cell_array.sv
module tb_pal_cell_array;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_out = '0;
  logic [2:0]  cfg_term = '0;
  logic [31:0] cfg_fuses = '0;
  logic [9:0]  ded_in = '0;
  logic [7:0]  io_in = '0;
  logic [7:0]  out_val;
  logic [7:0]  out_en;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  typedef struct {
    string      req;
    logic [7:0] v;
    logic [7:0] e;
  } exp_t;
  exp_t sb[$];

  logic [31:0] bf [8][8];

  always #2 clk = ~clk;

  pal_cell_array dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_out(cfg_out),
    .cfg_term(cfg_term), .cfg_fuses(cfg_fuses), .ded_in(ded_in),
    .io_in(io_in), .out_val(out_val), .out_en(out_en)
  );

  function automatic logic [31:0] lt(int s); return 32'd1 << (2*s); endfunction
  function automatic logic [31:0] lc(int s); return 32'd1 << (2*s+1); endfunction

  function automatic logic tm(logic [31:0] f, logic [15:0] s);
    logic [15:0] tmask, cmask;
    for (int i = 0; i < 16; i++) begin
      tmask[i] = f[2*i];
      cmask[i] = f[2*i+1];
    end
    return ((tmask & ~s) == 16'd0) && ((cmask & s) == 16'd0);
  endfunction

  // Settle feedback by iterating to a fixed point.
  task automatic model(input logic [9:0] d, input logic [7:0] io,
                       output logic [7:0] v, output logic [7:0] e);
    logic [5:0] fb, nf;
    logic sum;
    fb = io[6:1];
    v = '0; e = '0;
    for (int it = 0; it < 12; it++) begin
      for (int o = 0; o < 8; o++) begin
        sum = 1'b0;
        for (int t = 0; t < 7; t++) sum = sum | tm(bf[o][t], {fb, d});
        v[o] = ~sum;
        e[o] = tm(bf[o][7], {fb, d});
      end
      for (int j = 0; j < 6; j++) nf[j] = e[j+1] ? v[j+1] : io[j+1];
      if (nf == fb) break;
      fb = nf;
    end
  endtask

  task automatic wr(input int o, input int t, input logic [31:0] f);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_out = 3'(o); cfg_term = 3'(t); cfg_fuses = f;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    bf[o][t] = f;
  endtask

  task automatic apply(input string req, input logic [9:0] d, input logic [7:0] io);
    exp_t x;
    @(posedge clk); #1;
    ded_in = d; io_in = io;
    model(d, io, x.v, x.e);
    x.req = req;
    sb.push_back(x);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        total++;
        if (out_val !== x.v || out_en !== x.e) begin
          bad++;
          $display("FAIL %s: val=%h en=%h expected val=%h en=%h",
                   x.req, out_val, out_en, x.v, x.e);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++;
        $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    for (int o = 0; o < 8; o++)
      for (int t = 0; t < 8; t++) bf[o][t] = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state under several pin patterns
    apply("R1", 10'h3ff, 8'hff);
    apply("R1", 10'h000, 8'h00);
    apply("R1", 10'h155, 8'haa);

    // R4 / R8: empty enable term on output 0
    wr(0, 7, 32'h0);
    apply("R4", 10'h000, 8'h00);

    // R2: term = d0 & ~d1
    wr(0, 0, lt(0) | lc(1));
    apply("R2", 10'h001, 8'h00);
    apply("R2", 10'h003, 8'h00);
    apply("R2", 10'h000, 8'h00);

    // R3: second sum term d2
    wr(0, 1, lt(2));
    apply("R3", 10'h004, 8'h00);
    apply("R3", 10'h005, 8'h00);
    apply("R3", 10'h006, 8'h00);
    apply("R3", 10'h002, 8'h00);

    // R4: enable follows d9 on output 3
    wr(3, 7, lt(9));
    wr(3, 0, lc(8));
    apply("R4", 10'h200, 8'h00);
    apply("R4", 10'h300, 8'h00);
    apply("R4", 10'h000, 8'h00);

    // R5: output 2 terms leave others alone
    wr(2, 0, lt(5));
    apply("R5", 10'h020, 8'h00);
    apply("R5", 10'h001, 8'h00);

    // R6: helper chain out1 -> out4 -> out2
    wr(1, 7, 32'h0);
    wr(1, 0, lt(3) | lt(4));
    wr(4, 7, 32'h0);
    wr(4, 0, lt(10));
    wr(2, 1, lc(13));
    apply("R6", 10'h018, 8'h00);
    apply("R6", 10'h008, 8'h00);
    apply("R6", 10'h038, 8'h00);

    // R7: disabled out6 pin feeds out5; enabled out1 ignores its pin
    wr(5, 7, 32'h0);
    wr(5, 0, lt(15));
    apply("R7", 10'h018, 8'h40);
    apply("R7", 10'h018, 8'h00);
    apply("R7", 10'h018, 8'h02);
    apply("R7", 10'h008, 8'h12);

    // R9: pins of non-fed-back outputs
    apply("R9", 10'h018, 8'h81);
    apply("R9", 10'h018, 8'h01);

    // R8: overwrite terms
    wr(0, 0, 32'h0);
    apply("R8", 10'h000, 8'h00);
    wr(0, 7, 32'hffff_ffff);
    apply("R8", 10'h000, 8'h00);

    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule